// File: doc/BRIEF.md
# Keyed Independent Watchdog Timer

A down-counting watchdog that runs from its own low-speed clock. It sits behind a small register port on the system clock. That port has four words: a key word, a prescaler word, a reload word and a status word. Software starts the watchdog with one key value and refreshes it with a second. Changes to the prescaler and reload words are accepted only after a third key value has lifted write protection. Writing any other key value restores the protection.

Accepted prescaler and reload values cross into the watchdog clock domain through a toggle handshake. While a value is in flight, its busy bit in the status word stays set and further writes to that word are dropped. The busy bit clears only after the counter domain holds the new value. Reads of the prescaler and reload words return the copy held in the counter domain.

Once started, the counter cannot be stopped. If software does not refresh it in time, it reaches zero and raises a reset request for one watchdog clock cycle. It then reloads and keeps counting.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the reload word reads 0x00000FFF, the prescaler word reads 0, the status word reads 0 and the reset request is low.
- R2: The reload value is 12 bits wide, in bits 11:0. Bits 31:12 of the reload word read as zero, and write data in those bits is ignored.
- R3: Writing 0x5555 in bits 15:0 of the key word (address 0) lifts write protection. Writing any other key value restores it. While protection is in place, writes to the prescaler word (address 1) and the reload word (address 2) are ignored.
- R4: An accepted write sets a busy bit in the status word (address 3): bit 0 for the prescaler, bit 1 for the reload. The bit stays set until the counter domain holds the new value. After it clears, the word reads back the written value.
- R5: A write to the prescaler or reload word while its busy bit is set is ignored.
- R6: Before key 0xCCCC has been written, the reset request never asserts.
- R7: Once started and left unrefreshed, the block gives reset request pulses that are exactly one watchdog clock cycle wide and exactly (reload+1)×divider watchdog clock cycles apart.
- R8: A prescaler code c (3 bits, bits 2:0 of address 1) divides by 4·2^c for c from 0 to 6. Code 7 also divides by 256.
- R9: Writing key 0xAAAA reloads the counter from the reload value and restarts the prescaler. Refreshes made more often than the timeout keep the reset request low.
- R10: Once started, the watchdog keeps running whatever key values are written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wdt_clk | input | 1 | Low-speed watchdog clock |
| bus_wr | input | 1 | Write strobe, sampled on clk |
| bus_addr | input | 2 | Word select: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| wdt_rst_req | output | 1 | Reset request, one wdt_clk cycle wide |

## Verification
The assertions check on every cycle that the reset request is a single-cycle pulse, and that it stays low until the watchdog has started. They also check that a started watchdog never stops, that a protected write never sets a busy bit, and that a held value does not change while its transfer is in flight. Only the bench's scenarios can show the exact timeout spacing for each prescaler code and that refreshes hold off the request. They also show the reset values and the read-back after a handshake completes, because these depend on sequences of writes across both clocks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
   localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
   localparam logic [15:0] KEY_START   = 16'hCCCC;

   typedef enum logic [1:0] {
      SEL_KEY = 2'd0,
      SEL_PSC = 2'd1,
      SEL_RLD = 2'd2,
      SEL_STS = 2'd3
   } kwdt_sel_e;

endpackage

// File: rtl/kwdt_pulse_sync.sv
// Carries single-cycle events from the register clock into the watchdog clock
// by toggling a level and detecting its edges after a synchronizer chain.
module kwdt_pulse_sync #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic src_pulse,
   output logic dst_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("kwdt_pulse_sync: STAGES must be at least 2");
      end
   endgenerate

   logic              tgl;
   logic [STAGES-1:0] sync_q;
   logic              seen;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else if (src_pulse) tgl <= ~tgl;
   end

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '0;
         seen      <= 1'b0;
         dst_pulse <= 1'b0;
      end else begin
         sync_q    <= {sync_q[STAGES-2:0], tgl};
         seen      <= sync_q[STAGES-1];
         dst_pulse <= sync_q[STAGES-1] ^ seen;
      end
   end
endmodule

// File: rtl/kwdt_xfer.sv
// Moves a configuration value from the register clock into the watchdog
// clock. busy stays high from the accepted load until the acknowledge,
// raised in the same edge that updates dout, returns to the source side.
module kwdt_xfer #(
   parameter int              W      = 12,
   parameter int              STAGES = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         busy,
   output logic [W-1:0] dout
);
   generate
      if (W < 1) begin : g_bad_width
         $error("kwdt_xfer: W must be positive");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("kwdt_xfer: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0]      hold;
   logic              req;
   logic [STAGES-1:0] ack_sync;
   logic [STAGES-1:0] req_sync;
   logic              ack;

   // source side
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= RST_VAL;
         req      <= 1'b0;
         ack_sync <= '0;
      end else begin
         ack_sync <= {ack_sync[STAGES-2:0], ack};
         if (load && !busy) begin
            hold <= din;
            req  <= ~req;
         end
      end
   end

   assign busy = req ^ ack_sync[STAGES-1];

   // destination side
   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_sync <= '0;
         ack      <= 1'b0;
         dout     <= RST_VAL;
      end else begin
         req_sync <= {req_sync[STAGES-2:0], req};
         if (req_sync[STAGES-1] != ack) begin
            dout <= hold;
            ack  <= req_sync[STAGES-1];
         end
      end
   end

   // R5: a write arriving while busy must leave the held value alone
   p_busy_write_ignored_r5 : assert property (@(posedge src_clk) disable iff (!rst_n)
      (load && busy) |=> $stable(hold));

endmodule

// File: rtl/kwdt_counter.sv
// Watchdog-clock countdown with a power-of-two prescaler.
module kwdt_counter #(
   parameter int             RLW       = 12,
   parameter int             PSW       = 3,
   parameter int             MIN_SHIFT = 2,
   parameter int             MAX_CODE  = 6,
   parameter logic [RLW-1:0] RL_RST    = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_p,
   input  logic           refresh_p,
   input  logic [RLW-1:0] reload,
   input  logic [PSW-1:0] psc,
   output logic           rst_req
);
   localparam int DIVW = MIN_SHIFT + MAX_CODE;

   generate
      if (MAX_CODE >= (1 << PSW)) begin : g_bad_code
         $error("kwdt_counter: MAX_CODE does not fit in PSW bits");
      end
      if (MIN_SHIFT < 1) begin : g_bad_shift
         $error("kwdt_counter: MIN_SHIFT must be at least 1");
      end
   endgenerate

   logic [DIVW-1:0] pcnt;
   logic [DIVW:0]   div_m1;
   logic [RLW-1:0]  cnt;
   logic            running;
   logic            tick;
   int              code_eff;

   always_comb begin
      code_eff = (int'(psc) > MAX_CODE) ? MAX_CODE : int'(psc);
      div_m1   = ({{DIVW{1'b0}}, 1'b1} << (code_eff + MIN_SHIFT)) - {{DIVW{1'b0}}, 1'b1};
      tick     = ({1'b0, pcnt} >= div_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= RL_RST;
         pcnt    <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (start_p) running <= 1'b1;
         if ((start_p && !running) || refresh_p) begin
            cnt  <= reload;
            pcnt <= '0;
         end else if (running) begin
            if (tick) begin
               pcnt <= '0;
               if (cnt == '0) begin
                  rst_req <= 1'b1;
                  cnt     <= reload;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
      end
   end

   // R7: request is a single watchdog-clock cycle
   p_req_one_cycle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R6: no request before the watchdog has been started
   p_idle_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !rst_req);
   // R10: a started watchdog stays started
   p_no_stop_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import kwdt_pkg::*;
#(
   parameter int             RLW       = 12,
   parameter int             PSW       = 3,
   parameter int             MIN_SHIFT = 2,
   parameter int             MAX_CODE  = 6,
   parameter int             STAGES    = 2,
   parameter logic [RLW-1:0] RL_RST    = '1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wdt_clk,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        wdt_rst_req
);
   generate
      if (RLW < 1 || RLW > 16) begin : g_bad_rlw
         $error("keyed_wdt: RLW out of range");
      end
      if (PSW < 1 || PSW > 8) begin : g_bad_psw
         $error("keyed_wdt: PSW out of range");
      end
   endgenerate

   kwdt_sel_e      sel;
   logic           key_wr, unlocked;
   logic           psc_ld, rld_ld;
   logic           psc_busy, rld_busy;
   logic [PSW-1:0] psc_cur;
   logic [RLW-1:0] rld_cur;
   logic           start_req, refresh_req;
   logic           start_w, refresh_w;
   logic           wdt_unused_hi;

   assign sel           = kwdt_sel_e'(bus_addr);
   assign key_wr        = bus_wr && (sel == SEL_KEY);
   assign psc_ld        = bus_wr && (sel == SEL_PSC) && unlocked;
   assign rld_ld        = bus_wr && (sel == SEL_RLD) && unlocked;
   assign start_req     = key_wr && (bus_wdata[15:0] == KEY_START);
   assign refresh_req   = key_wr && (bus_wdata[15:0] == KEY_REFRESH);
   assign wdt_unused_hi = ^bus_wdata[31:16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unlocked <= 1'b0;
      else if (key_wr) unlocked <= (bus_wdata[15:0] == KEY_UNLOCK);
   end

   kwdt_xfer #(.W(PSW), .STAGES(STAGES), .RST_VAL('0)) psc_xfer_i (
      .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
      .load(psc_ld), .din(bus_wdata[PSW-1:0]),
      .busy(psc_busy), .dout(psc_cur)
   );

   kwdt_xfer #(.W(RLW), .STAGES(STAGES), .RST_VAL(RL_RST)) rld_xfer_i (
      .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
      .load(rld_ld), .din(bus_wdata[RLW-1:0]),
      .busy(rld_busy), .dout(rld_cur)
   );

   kwdt_pulse_sync #(.STAGES(STAGES)) start_sync_i (
      .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
      .src_pulse(start_req), .dst_pulse(start_w)
   );

   kwdt_pulse_sync #(.STAGES(STAGES)) refresh_sync_i (
      .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
      .src_pulse(refresh_req), .dst_pulse(refresh_w)
   );

   kwdt_counter #(.RLW(RLW), .PSW(PSW), .MIN_SHIFT(MIN_SHIFT),
                  .MAX_CODE(MAX_CODE), .RL_RST(RL_RST)) cnt_i (
      .clk(wdt_clk), .rst_n(rst_n),
      .start_p(start_w), .refresh_p(refresh_w),
      .reload(rld_cur), .psc(psc_cur),
      .rst_req(wdt_rst_req)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_PSC: bus_rdata[PSW-1:0] = psc_cur;
         SEL_RLD: bus_rdata[RLW-1:0] = rld_cur;
         SEL_STS: bus_rdata[1:0]     = {rld_busy, psc_busy};
         default: bus_rdata = '0;
      endcase
   end

   // R3: a protected write never starts a transfer
   p_locked_rld_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_RLD && !unlocked && !rld_busy) |=> !rld_busy);
   p_locked_psc_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_PSC && !unlocked && !psc_busy) |=> !psc_busy);

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
   logic        clk = 1'b0;
   logic        wdt_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_rst_req;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int wcyc = 0;
   int pulse_cnt = 0;
   int last_stamp = 0;
   int last_interval = 0;
   int wide_cnt = 0;
   bit prev_high = 0;

   always #5 clk = ~clk;
   always #35 wdt_clk = ~wdt_clk;

   keyed_wdt dut_i (
      .clk(clk), .rst_n(rst_n), .wdt_clk(wdt_clk),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
   );

   always @(posedge wdt_clk) wcyc = wcyc + 1;

   always @(negedge wdt_clk) begin
      if (rst_n && wdt_rst_req) begin
         if (prev_high) wide_cnt = wide_cnt + 1;
         pulse_cnt     = pulse_cnt + 1;
         last_interval = wcyc - last_stamp;
         last_stamp    = wcyc;
      end
      prev_high = rst_n && wdt_rst_req;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 400; i++) begin
         rd(2'd3, s);
         if (s[1:0] == 2'b00) break;
      end
   endtask

   // interval between two complete pulses that follow the call
   task automatic measure(input int exp, input string tag);
      int p;
      p = pulse_cnt;
      while (pulse_cnt < p + 2) @(posedge clk);
      check(last_interval == exp, tag, last_interval, exp);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd2, v); check(v == 32'h0000_0FFF, "R1 reload reset", v, 32'hFFF);
      rd(2'd1, v); check(v == 32'h0, "R1 prescaler reset", v, 0);
      rd(2'd3, v); check(v == 32'h0, "R1 status reset", v, 0);
      check(wdt_rst_req == 1'b0, "R1 request low", wdt_rst_req, 0);
   endtask

   task automatic t_protect();
      logic [31:0] v;
      wr(2'd2, 32'h0000_0123);
      rd(2'd3, v); check(v == 32'h0, "R3 locked write no busy", v, 0);
      wait_idle();
      rd(2'd2, v); check(v == 32'h0000_0FFF, "R3 locked reload kept", v, 32'hFFF);
   endtask

   task automatic t_update();
      logic [31:0] v;
      wr(2'd0, 32'h0000_5555);
      wr(2'd2, 32'hFFFF_F005);
      wr(2'd2, 32'h0000_0007);
      rd(2'd3, v); check(v[1] == 1'b1, "R4 reload busy set", v, 2);
      wait_idle();
      rd(2'd3, v); check(v == 32'h0, "R4 busy cleared", v, 0);
      rd(2'd2, v); check(v == 32'h0000_0005, "R2 R5 reload readback", v, 5);
      wr(2'd1, 32'h0000_0003);
      rd(2'd3, v); check(v[0] == 1'b1, "R4 prescaler busy set", v, 1);
      wait_idle();
      rd(2'd1, v); check(v == 32'h3, "R4 prescaler readback", v, 3);
      wr(2'd1, 32'h0000_0000);
      wait_idle();
      wr(2'd0, 32'h0000_1234);
      wr(2'd1, 32'h0000_0006);
      wait_idle();
      rd(2'd1, v); check(v == 32'h0, "R3 relocked prescaler kept", v, 0);
   endtask

   task automatic t_idle();
      repeat (400) @(posedge clk);
      check(pulse_cnt == 0, "R6 no request before start", pulse_cnt, 0);
   endtask

   task automatic t_timeout();
      wr(2'd0, 32'h0000_CCCC);
      measure(24, "R7 interval rl5 div4");
      check(wide_cnt == 0, "R7 one cycle pulse", wide_cnt, 0);
   endtask

   task automatic t_refresh();
      int p;
      p = pulse_cnt;
      for (int i = 0; i < 20; i++) begin
         wr(2'd0, 32'h0000_AAAA);
         repeat (80) @(posedge clk);
      end
      check(pulse_cnt == p, "R9 refresh holds off request", pulse_cnt - p, 0);
   endtask

   task automatic t_no_stop();
      wr(2'd0, 32'h0000_0000);
      wr(2'd0, 32'h0000_CCCC);
      measure(24, "R10 keeps running");
   endtask

   task automatic t_prescale();
      logic [31:0] v;
      wr(2'd0, 32'h0000_5555);
      wr(2'd1, 32'h0000_0002);
      wr(2'd2, 32'h0000_0003);
      wait_idle();
      measure(64, "R8 code2 rl3");
      wr(2'd1, 32'h0000_0007);
      wr(2'd2, 32'h0000_0001);
      wait_idle();
      rd(2'd1, v); check(v == 32'h7, "R8 code7 readback", v, 7);
      measure(512, "R8 code7 rl1");
      check(wide_cnt == 0, "R7 pulses stay one cycle", wide_cnt, 0);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(posedge clk);
      t_reset();
      t_protect();
      t_update();
      t_idle();
      t_timeout();
      t_refresh();
      t_no_stop();
      t_prescale();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule